// File: doc/BRIEF.md
# Program Memory Erase/Program/Read Sequencer

This block runs the erase, byte-program and byte-read operations on two on-chip program memory banks: a large application bank and a small loader bank. Software sets up an operation through four byte-wide special function registers: the high byte of a 16-bit target address, the low byte, a data byte and a control byte. A single-cycle start strobe stands in for the core entering its idle state. The block then holds `busy` for a fixed number of cycles that depends on the operation and pulses `done` when the operation is complete. A read places the addressed byte into the data register, which is visible on `dataOut`.

A security byte lives at address 0xFFFF of the loader space. Its bits can only be cleared by programming. They return to 1 only when the loader bank is erased in full. Bit 0 of this byte is the lock bit: while it is 0, no read returns array or security contents. The memories are plain behavioural arrays whose depth is set by parameters, and a reset loads them with their erased value.

Top module: `nvm_prog_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, `dataOut` is 0x00, every byte of both banks reads 0xFF, and the security byte is 0xFF.
- R2: While `busy` is 0, a pulse on `sfrWr` loads `sfrWdata` into the register chosen by `sfrSel`: 0 selects address high, 1 selects address low, 2 selects the data register, 3 selects control. While `busy` is 1, register writes are ignored.
- R3: In the control byte, bit 6 selects the bank (0 = application, 1 = loader), bit 5 is output-enable, bit 4 is chip-enable, and bits 3:0 are the opcode. The valid commands are: erase (0010 with OE=1, CE=0), program (0001 with OE=1, CE=0) and read (0000 with OE=0, CE=0). Bit 7 is ignored. A start with any other combination causes no `busy` and no `done`.
- R4: `busy` rises in the cycle after the accepted start and stays high for READ_CYC (2) cycles on a read, PROG_CYC (4) on a program and ERASE_CYC (12) on an erase. `done` is high for exactly one cycle, the first cycle after `busy` falls. A start while busy is ignored.
- R5: An erase sets every byte of the selected bank to 0xFF and leaves the other bank unchanged.
- R6: A program replaces the addressed byte with (stored AND data). The byte index is the address modulo the bank depth: 256 for application, 64 for loader.
- R7: A read loads the addressed byte into the data register, and the result is on `dataOut` when `done` is high.
- R8: Loader-bank address 0xFFFF reaches the security byte instead of the array. Programming it applies sec = sec AND (data OR 0x78), so bits 6:3 stay 1 and no bit ever goes from 0 to 1.
- R9: A loader-bank erase restores the security byte to 0xFF. An application-bank erase does not change it.
- R10: While security bit 0 is 0, every read returns 0x00, whether it targets the application bank, the loader bank or the security byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrWr | input | 1 | Register write strobe |
| sfrSel | input | 2 | Register select: 0 addr high, 1 addr low, 2 data, 3 control |
| sfrWdata | input | 8 | Register write data |
| start | input | 1 | Operation start strobe (idle entry) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dataOut | output | 8 | Data register contents |

## Verification
The bench targets several cases. Repeated programming of the same byte must give the AND of all the data written; a design that overwrites the byte instead of ANDing would read back the last data. It aliases addresses above the bank depth onto the same byte, and checks that the banks do not touch each other, so a wrong bank select shows up as a changed byte in the other bank. Near-miss control bytes must produce no `busy` at all, and register writes and a second start issued mid-operation must not extend the operation or corrupt it. For the security byte, the bench tries to set bits again and to clear the reserved bits, checks that an application erase keeps the byte while a loader erase restores it, and checks that a lock blocks reads of both banks and of the security byte itself.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} nvmOp_e;

  typedef struct packed {
    logic   commit;
    nvmOp_e op;
    logic   loaderBank;
  } nvmStrobe_t;

  localparam logic [1:0]  SEL_ADDR_HI = 2'd0;
  localparam logic [1:0]  SEL_ADDR_LO = 2'd1;
  localparam logic [1:0]  SEL_DATA    = 2'd2;
  localparam logic [1:0]  SEL_CTRL    = 2'd3;

  localparam int          CTRL_BANK_BIT = 6;
  localparam int          CTRL_OE_BIT   = 5;
  localparam int          CTRL_CE_BIT   = 4;

  localparam logic [3:0]  CODE_READ  = 4'b0000;
  localparam logic [3:0]  CODE_PROG  = 4'b0001;
  localparam logic [3:0]  CODE_ERASE = 4'b0010;

  localparam logic [15:0] SEC_ADDR = 16'hFFFF;
  localparam logic [7:0]  SEC_KEEP = 8'h78;
endpackage

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int READ_CYC  = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [6:0] ctrlByte,
  output logic       busy,
  output logic       done,
  output nvmStrobe_t strb
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ?
                           ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC) :
                           ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  nvmOp_e        cmdOp;
  nvmOp_e        curOp;
  logic          curBank;
  logic [CW-1:0] cnt;
  logic [CW-1:0] loadCnt;
  logic          oeBit, ceBit;
  logic [3:0]    code;

  assign oeBit = ctrlByte[CTRL_OE_BIT];
  assign ceBit = ctrlByte[CTRL_CE_BIT];
  assign code  = ctrlByte[3:0];

  always_comb begin
    cmdOp = OP_NONE;
    if (!ceBit) begin
      if (oeBit && code == CODE_ERASE)      cmdOp = OP_ERASE;
      else if (oeBit && code == CODE_PROG)  cmdOp = OP_PROG;
      else if (!oeBit && code == CODE_READ) cmdOp = OP_READ;
    end
  end

  always_comb begin
    case (cmdOp)
      OP_ERASE: loadCnt = CW'(ERASE_CYC - 1);
      OP_PROG:  loadCnt = CW'(PROG_CYC - 1);
      default:  loadCnt = CW'(READ_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      curOp   <= OP_NONE;
      curBank <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start && cmdOp != OP_NONE) begin
        busy    <= 1'b1;
        cnt     <= loadCnt;
        curOp   <= cmdOp;
        curBank <= ctrlByte[CTRL_BANK_BIT];
      end
    end
  end

  assign strb.commit     = busy && (cnt == '0);
  assign strb.op         = curOp;
  assign strb.loaderBank = curBank;

  // R4: done lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4: busy only starts from a start strobe
  p_busy_from_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R4: completion pulse accompanies busy falling
  p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R3: rejected command never launches an operation
  p_bad_cmd_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && cmdOp == OP_NONE) |=> !busy);
endmodule

// File: rtl/nvm_store.sv
module nvm_store
  import nvm_pkg::*;
#(
  parameter int APP_AW = 8,
  parameter int LDR_AW = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfrWr,
  input  logic [1:0] sfrSel,
  input  logic [7:0] sfrWdata,
  input  logic       busy,
  input  nvmStrobe_t strb,
  output logic [6:0] ctrlByte,
  output logic [7:0] dataOut
);
  localparam int APP_DEPTH = 1 << APP_AW;
  localparam int LDR_DEPTH = 1 << LDR_AW;

  logic [7:0]        appMem [APP_DEPTH];
  logic [7:0]        ldrMem [LDR_DEPTH];
  logic [7:0]        secByte;
  logic [7:0]        addrHi, addrLo, dataReg;
  logic [6:0]        ctrlReg;
  logic [15:0]       addr;
  logic [APP_AW-1:0] appIdx;
  logic [LDR_AW-1:0] ldrIdx;
  logic              isSec;
  logic              locked;
  logic [7:0]        curByte;

  assign addr    = {addrHi, addrLo};
  assign appIdx  = addr[APP_AW-1:0];
  assign ldrIdx  = addr[LDR_AW-1:0];
  assign isSec   = strb.loaderBank && (addr == SEC_ADDR);
  assign locked  = !secByte[0];
  assign curByte = isSec ? secByte :
                   (strb.loaderBank ? ldrMem[ldrIdx] : appMem[appIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi  <= '0;
      addrLo  <= '0;
      dataReg <= '0;
      ctrlReg <= '0;
      secByte <= 8'hFF;
      for (int i = 0; i < APP_DEPTH; i++) appMem[i] <= 8'hFF;
      for (int i = 0; i < LDR_DEPTH; i++) ldrMem[i] <= 8'hFF;
    end else begin
      if (sfrWr && !busy) begin
        case (sfrSel)
          SEL_ADDR_HI: addrHi  <= sfrWdata;
          SEL_ADDR_LO: addrLo  <= sfrWdata;
          SEL_DATA:    dataReg <= sfrWdata;
          default:     ctrlReg <= sfrWdata[6:0];
        endcase
      end
      if (strb.commit) begin
        case (strb.op)
          OP_ERASE: begin
            if (strb.loaderBank) begin
              for (int i = 0; i < LDR_DEPTH; i++) ldrMem[i] <= 8'hFF;
              secByte <= 8'hFF;
            end else begin
              for (int i = 0; i < APP_DEPTH; i++) appMem[i] <= 8'hFF;
            end
          end
          OP_PROG: begin
            if (isSec)                 secByte        <= secByte & (dataReg | SEC_KEEP);
            else if (strb.loaderBank)  ldrMem[ldrIdx] <= ldrMem[ldrIdx] & dataReg;
            else                       appMem[appIdx] <= appMem[appIdx] & dataReg;
          end
          OP_READ: dataReg <= locked ? 8'h00 : curByte;
          default: ;
        endcase
      end
    end
  end

  assign ctrlByte = ctrlReg;
  assign dataOut  = dataReg;

  // R2: set-up registers frozen during an operation
  p_regs_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({addrHi, addrLo, ctrlReg}));
  // R8: security bits never return to 1 except through a loader erase
  p_sec_clear_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit && strb.op == OP_ERASE && strb.loaderBank)
      |=> ((secByte & ~$past(secByte)) == 8'h00));
  // R8: reserved security bits remain set
  p_sec_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    secByte[6:3] == 4'hF);
  // R10: a read under lock yields zero
  p_locked_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_READ && locked) |=> dataOut == 8'h00);
endmodule

// File: rtl/nvm_prog_unit.sv
module nvm_prog_unit
  import nvm_pkg::*;
#(
  parameter int APP_AW    = 8,
  parameter int LDR_AW    = 6,
  parameter int READ_CYC  = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfrWr,
  input  logic [1:0] sfrSel,
  input  logic [7:0] sfrWdata,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic [7:0] dataOut
);
  nvmStrobe_t strb;
  logic [6:0] ctrlByte;

  nvm_seq #(
    .READ_CYC (READ_CYC),
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) uSeq (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctrlByte(ctrlByte),
    .busy    (busy),
    .done    (done),
    .strb    (strb)
  );

  nvm_store #(
    .APP_AW(APP_AW),
    .LDR_AW(LDR_AW)
  ) uStore (
    .clk     (clk),
    .rstN    (rstN),
    .sfrWr   (sfrWr),
    .sfrSel  (sfrSel),
    .sfrWdata(sfrWdata),
    .busy    (busy),
    .strb    (strb),
    .ctrlByte(ctrlByte),
    .dataOut (dataOut)
  );
endmodule

// File: tb/sim_nvm_prog_unit.sv
`timescale 1ns/1ps
module sim_nvm_prog_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sfrWr = 1'b0;
  logic [1:0] sfrSel = 2'd0;
  logic [7:0] sfrWdata = 8'h00;
  logic       start = 1'b0;
  logic       busy, done;
  logic [7:0] dataOut;

  int tests = 0;
  int fails = 0;

  logic [7:0] appM [256];
  logic [7:0] ldrM [64];
  logic [7:0] secM;

  always #10 clk = ~clk;

  nvm_prog_unit #(.APP_AW(8), .LDR_AW(6), .READ_CYC(2), .PROG_CYC(4), .ERASE_CYC(12)) u0 (
    .clk(clk), .rstN(rstN), .sfrWr(sfrWr), .sfrSel(sfrSel), .sfrWdata(sfrWdata),
    .start(start), .busy(busy), .done(done), .dataOut(dataOut));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(input bit ldr, input logic [15:0] a);
    if (!secM[0]) return 8'h00;
    if (ldr && a == 16'hFFFF) return secM;
    return ldr ? ldrM[a[5:0]] : appM[a[7:0]];
  endfunction

  function automatic int cycFor(input logic [3:0] code);
    return (code == 4'b0010) ? 12 : ((code == 4'b0001) ? 4 : 2);
  endfunction

  task automatic sfr(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    sfrWr = 1'b1; sfrSel = s; sfrWdata = v;
    @(negedge clk);
    sfrWr = 1'b0;
  endtask

  // Launch one valid command, check its timing, update model, check read data.
  task automatic op(input logic [7:0] ctrl, input logic [15:0] a, input logic [7:0] d,
                    input string tag);
    int n;
    bit ldr;
    logic [3:0] code;
    ldr  = ctrl[6];
    code = ctrl[3:0];
    sfr(2'd0, a[15:8]);
    sfr(2'd1, a[7:0]);
    sfr(2'd2, d);
    sfr(2'd3, ctrl);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == cycFor(code), {tag, " R4 busy length"}, n, cycFor(code));
    chk(done == 1'b1, {tag, " R4 done pulse"}, done, 1);
    if (code == 4'b0010) begin
      if (ldr) begin
        for (int i = 0; i < 64; i++) ldrM[i] = 8'hFF;
        secM = 8'hFF;
      end else begin
        for (int i = 0; i < 256; i++) appM[i] = 8'hFF;
      end
    end else if (code == 4'b0001) begin
      if (ldr && a == 16'hFFFF) secM = secM & (d | 8'h78);
      else if (ldr)             ldrM[a[5:0]] = ldrM[a[5:0]] & d;
      else                      appM[a[7:0]] = appM[a[7:0]] & d;
    end else begin
      chk(dataOut == mRead(ldr, a), {tag, " read data"}, dataOut, mRead(ldr, a));
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R4 done single"}, done, 0);
  endtask

  task automatic badCmd(input logic [7:0] ctrl, input string tag);
    sfr(2'd3, ctrl);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy == 1'b0 && done == 1'b0, {tag, " R3 rejected command"}, {busy, done}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) appM[i] = 8'hFF;
    for (int i = 0; i < 64; i++)  ldrM[i] = 8'hFF;
    secM = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle after reset", {busy, done}, 0);
    chk(dataOut == 8'h00, "R1 data register reset", dataOut, 0);

    op(8'h00, 16'h0010, 8'h00, "R1 R7 erased app read");
    op(8'h40, 16'h0007, 8'h00, "R1 R7 erased loader read");
    op(8'h21, 16'h0010, 8'hA5, "R6 program");
    op(8'h00, 16'h0010, 8'h00, "R6 R7 readback");
    op(8'h21, 16'h0010, 8'h3C, "R6 program AND");
    op(8'h00, 16'h0010, 8'h00, "R6 AND readback");
    op(8'h00, 16'h0110, 8'h00, "R6 alias beyond depth");
    op(8'hA1, 16'h0011, 8'h5A, "R3 bit7 ignored program");
    op(8'h00, 16'h0011, 8'h00, "R3 bit7 readback");
    op(8'h61, 16'h0005, 8'h12, "R3 loader program");
    op(8'h40, 16'h0045, 8'h00, "R6 loader alias read");
    op(8'h00, 16'h0005, 8'h00, "R3 bank isolation");
    op(8'h22, 16'h0000, 8'h00, "R5 app erase");
    op(8'h00, 16'h0010, 8'h00, "R5 app erased");
    op(8'h40, 16'h0005, 8'h00, "R5 loader untouched");

    sfr(2'd2, 8'h00);
    badCmd(8'h31, "CE high");
    badCmd(8'h01, "program OE low");
    badCmd(8'h20, "read OE high");
    badCmd(8'h23, "opcode 3");
    op(8'h00, 16'h0010, 8'h00, "R3 no effect of rejected");

    // R2/R4: writes and start during busy are ignored
    sfr(2'd0, 8'h00); sfr(2'd1, 8'h20); sfr(2'd2, 8'h0F); sfr(2'd3, 8'h21);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 1;
    sfrWr = 1'b1; sfrSel = 2'd2; sfrWdata = 8'h00; start = 1'b1;
    @(negedge clk);
    sfrWr = 1'b0; start = 1'b0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == 4, "R4 start while busy", n, 4);
    chk(done == 1'b1, "R4 done after busy", done, 1);
    chk(dataOut == 8'h0F, "R2 data write ignored while busy", dataOut, 8'h0F);
    appM[8'h20] = 8'h0F;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0, "R4 no relaunch", busy, 0);
    end
    op(8'h00, 16'h0020, 8'h00, "R2 R6 programmed value");

    for (int it = 0; it < 40; it++) begin
      logic [15:0] ra;
      logic [7:0]  rd;
      bit          rl;
      ra = 16'($urandom);
      if (ra == 16'hFFFF) ra = 16'h0000;
      rd = 8'($urandom);
      rl = 1'($urandom);
      op(rl ? 8'h61 : 8'h21, ra, rd, "R6 random program");
      op(rl ? 8'h40 : 8'h00, ra, 8'h00, "R7 random read");
    end

    op(8'h40, 16'hFFFF, 8'h00, "R8 security default");
    op(8'h61, 16'hFFFF, 8'hFD, "R8 clear bit1");
    op(8'h40, 16'hFFFF, 8'h00, "R8 security readback");
    op(8'h61, 16'hFFFF, 8'hFF, "R8 no set back");
    op(8'h61, 16'hFFFF, 8'h81, "R8 reserved kept");
    op(8'h40, 16'hFFFF, 8'h00, "R8 security F9");
    op(8'h22, 16'h0000, 8'h00, "R9 app erase");
    op(8'h40, 16'hFFFF, 8'h00, "R9 security kept");
    op(8'h62, 16'h0000, 8'h00, "R9 loader erase");
    op(8'h40, 16'hFFFF, 8'h00, "R9 security restored");
    op(8'h40, 16'h0005, 8'h00, "R5 loader erased");

    op(8'h61, 16'h0005, 8'h33, "R10 loader data");
    op(8'h21, 16'h0010, 8'h44, "R10 app data");
    op(8'h61, 16'hFFFF, 8'hFE, "R10 set lock");
    op(8'h00, 16'h0010, 8'h00, "R10 app locked");
    op(8'h40, 16'h0005, 8'h00, "R10 loader locked");
    op(8'h40, 16'hFFFF, 8'h00, "R10 security locked");
    op(8'h62, 16'h0000, 8'h00, "R9 R10 unlock by erase");
    op(8'h00, 16'h0010, 8'h00, "R10 app readable again");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule